// File: doc/BRIEF.md
# Phase-Frequency Detector with Selectable Overlap Pulse

This block compares two divided clock streams, a reference stream and a feedback stream, and produces an UP request and a DOWN request for a downstream charge pump. A rising edge on the reference input sets the UP holder. A rising edge on the feedback input sets the DOWN holder. Once both holders are set, a common clear is raised after a short programmable interval, and that clear drops both holders together. Because of this, every comparison ends with a brief window in which UP and DOWN are high together. That overlap keeps the charge pump active at zero phase error, so the transfer function has no dead zone.

The interval before the clear is counted on the fast block clock `clk`. A 2-bit selector picks one of four overlap lengths. The reference and feedback inputs are synchronous level signals, such as the outputs of divider counters clocked by `clk`. Only their rising transitions are used. The block's outputs come straight from registers.

Top module: `pfd_abl`

## Requirements
- R1: While `rst` is high at a clock edge, `up_o` and `dn_o` are low after that edge.
- R2: When `ref_in` is high at an edge and was low at the previous edge, `up_o` is high after that edge. `fb_in` sets `dn_o` in the same way. An input that simply stays high sets nothing again.
- R3: A set output stays high until the common clear. The clear drops `up_o` and `dn_o` on the same edge, and neither output ever falls alone.
- R4: The overlap length W is the number of consecutive cycles in which both outputs are high before the clear. `delay_sel` = 2'b00 gives W = 3, 2'b01 gives W = 1, 2'b10 gives W = 5 and 2'b11 gives W = 3.
- R5: When both inputs rise at the same edge, both outputs are high for exactly W cycles, so a pulse appears even at zero phase error.
- R6: When one input rises d cycles before the other, the leading output is high for d + W cycles and the lagging output is high for W cycles.
- R7: A rising input edge seen on the same edge as the clear is dropped, and the cleared output stays low afterwards.
- R8: `delay_sel` is captured only on edges where both outputs are low. A change made during a pulse does not alter that pulse's width.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast delay clock; all logic runs on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ref_in | input | 1 | Divided reference stream |
| fb_in | input | 1 | Divided feedback stream |
| delay_sel | input | 2 | Overlap-length selector |
| up_o | output | 1 | UP request to the charge pump |
| dn_o | output | 1 | DOWN request to the charge pump |

## Verification
The bench covers coincident edges under every selector code. A design without the overlap would show no pulse at all at zero phase, and a miscounting timer would show a pulse one cycle too long or too short. It runs staggered edges in both directions and checks that the leading output carries the lag plus the overlap; a design that cleared each holder separately would fail this. It also raises a fresh reference edge exactly on the clearing edge, where a design that let the set win would leave UP stuck high. Finally, it changes the selector in the middle of a pulse, where a design that read the selector live would cut the pulse short.

// File: rtl/pfd_pkg.sv
package pfd_pkg;

  typedef logic [1:0] ovl_code_t;

  function automatic int unsigned max4(input int unsigned a, input int unsigned b,
                                       input int unsigned c, input int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/pfd_rise_det.sv
module pfd_rise_det (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic rise
);
  logic prev;

  always_ff @(posedge clk) begin
    if (rst) prev <= 1'b0;
    else     prev <= din;
  end

  assign rise = din & ~prev;
endmodule

// File: rtl/pfd_clr_timer.sv
module pfd_clr_timer
  import pfd_pkg::*;
#(
  parameter int unsigned W_00 = 3,
  parameter int unsigned W_01 = 1,
  parameter int unsigned W_10 = 5,
  parameter int unsigned W_11 = 3
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      both,
  input  logic      idle,
  input  ovl_code_t sel,
  output logic      clr
);
  localparam int unsigned WMAX  = max4(W_00, W_01, W_10, W_11);
  localparam int unsigned CNT_W = $clog2(WMAX + 1);

  logic [CNT_W-1:0] width_q;
  logic [CNT_W-1:0] width_d;
  logic [CNT_W-1:0] cnt;

  always_comb begin
    unique case (sel)
      2'b00:   width_d = CNT_W'(W_00);
      2'b01:   width_d = CNT_W'(W_01);
      2'b10:   width_d = CNT_W'(W_10);
      default: width_d = CNT_W'(W_11);
    endcase
  end

  assign clr = both && ((cnt + CNT_W'(1)) == width_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      width_q <= CNT_W'(W_00);
      cnt     <= '0;
    end else begin
      if (idle) width_q <= width_d;
      if (clr)       cnt <= '0;
      else if (both) cnt <= cnt + CNT_W'(1);
    end
  end
endmodule

// File: rtl/pfd_abl.sv
module pfd_abl
  import pfd_pkg::*;
#(
  parameter int unsigned W_00 = 3,
  parameter int unsigned W_01 = 1,
  parameter int unsigned W_10 = 5,
  parameter int unsigned W_11 = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ref_in,
  input  logic       fb_in,
  input  logic [1:0] delay_sel,
  output logic       up_o,
  output logic       dn_o
);
  localparam int NCH = 2;

  logic [NCH-1:0] raw;
  logic [NCH-1:0] rise;
  logic [NCH-1:0] hold;
  logic           clr;

  assign raw = {fb_in, ref_in};

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    pfd_rise_det u_det (
      .clk  (clk),
      .rst  (rst),
      .din  (raw[g]),
      .rise (rise[g])
    );

    always_ff @(posedge clk) begin
      if (rst)          hold[g] <= 1'b0;
      else if (clr)     hold[g] <= 1'b0;
      else if (rise[g]) hold[g] <= 1'b1;
    end
  end

  pfd_clr_timer #(
    .W_00 (W_00),
    .W_01 (W_01),
    .W_10 (W_10),
    .W_11 (W_11)
  ) u_tmr (
    .clk  (clk),
    .rst  (rst),
    .both (&hold),
    .idle (~|hold),
    .sel  (delay_sel),
    .clr  (clr)
  );

  assign up_o = hold[0];
  assign dn_o = hold[1];
endmodule

// File: rtl/pfd_abl_chk.sv
module pfd_abl_chk
  import pfd_pkg::*;
#(
  parameter int unsigned W_00 = 3,
  parameter int unsigned W_01 = 1,
  parameter int unsigned W_10 = 5,
  parameter int unsigned W_11 = 3
) (
  input logic       clk,
  input logic       rst,
  input logic       ref_in,
  input logic       fb_in,
  input logic [1:0] delay_sel,
  input logic       up_o,
  input logic       dn_o
);
  localparam int unsigned WMAX = max4(W_00, W_01, W_10, W_11);

  int unsigned ovl;

  always_ff @(posedge clk) begin
    if (rst)               ovl <= 0;
    else if (up_o && dn_o) ovl <= ovl + 1;
    else                   ovl <= 0;
  end

  // R2: a fresh rising edge on an idle channel sets its output
  p_up_set_r2: assert property (@(posedge clk) disable iff (rst)
    (!up_o && ref_in && !$past(ref_in)) |=> up_o);
  p_dn_set_r2: assert property (@(posedge clk) disable iff (rst)
    (!dn_o && fb_in && !$past(fb_in)) |=> dn_o);

  // R2: an output only rises after its input was high
  p_up_cause_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(up_o) |-> $past(ref_in));

  // R3: the outputs fall only together
  p_up_fall_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(up_o) |-> $fell(dn_o));
  p_dn_fall_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(dn_o) |-> $fell(up_o));

  // R4: the overlap never outlasts the longest setting
  p_ovl_bound_r4: assert property (@(posedge clk) disable iff (rst)
    ovl <= WMAX);
endmodule

bind pfd_abl pfd_abl_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .ref_in    (ref_in),
  .fb_in     (fb_in),
  .delay_sel (delay_sel),
  .up_o      (up_o),
  .dn_o      (dn_o)
);

// File: tb/sim_pfd_abl.sv
module sim_pfd_abl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ref_in = 1'b0;
  logic       fb_in = 1'b0;
  logic [1:0] delay_sel = 2'b00;
  logic       up_o;
  logic       dn_o;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  pfd_abl u0 (
    .clk       (clk),
    .rst       (rst),
    .ref_in    (ref_in),
    .fb_in     (fb_in),
    .delay_sel (delay_sel),
    .up_o      (up_o),
    .dn_o      (dn_o)
  );

  // {sel[11:10], ref rise index[9:5], fb rise index[4:0]}
  localparam int NV = 8;
  localparam logic [11:0] VEC [NV] = '{
    {2'b00, 5'd2, 5'd2}, {2'b01, 5'd2, 5'd2},
    {2'b10, 5'd2, 5'd2}, {2'b11, 5'd2, 5'd2},
    {2'b00, 5'd1, 5'd4}, {2'b10, 5'd5, 5'd2},
    {2'b01, 5'd3, 5'd7}, {2'b11, 5'd6, 5'd2}
  };

  function automatic int wsel(input logic [1:0] c);
    case (c)
      2'b00: return 3;
      2'b01: return 1;
      2'b10: return 5;
      default: return 3;
    endcase
  endfunction

  task automatic check(input string req, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, got, exp);
    end
  endtask

  task automatic settle(input logic [1:0] c);
    @(negedge clk);
    ref_in = 1'b0; fb_in = 1'b0; delay_sel = c;
    repeat (8) @(negedge clk);
  endtask

  initial begin
    int up_cnt, dn_cnt, up_first;
    repeat (3) @(negedge clk);
    check("R1 up after reset", int'(up_o), 0);
    check("R1 dn after reset", int'(dn_o), 0);
    rst = 1'b0;

    // R4 R5 R6: table walk
    for (int v = 0; v < NV; v++) begin
      int dr, df, w;
      dr = int'(VEC[v][9:5]);
      df = int'(VEC[v][4:0]);
      w  = wsel(VEC[v][11:10]);
      settle(VEC[v][11:10]);
      up_cnt = 0; dn_cnt = 0; up_first = -1;
      for (int i = 0; i < 20; i++) begin
        @(negedge clk);
        if (up_o) begin
          up_cnt++;
          if (up_first < 0) up_first = i;
        end
        if (dn_o) dn_cnt++;
        ref_in = (i >= dr);
        fb_in  = (i >= df);
      end
      check("R2 up start", up_first, dr + 1);
      check("R5 R6 up width", up_cnt, (df > dr ? df - dr : 0) + w);
      check("R4 R6 dn width", dn_cnt, (dr > df ? dr - df : 0) + w);
    end

    // R7: reference edge on the clearing edge is dropped (W = 1)
    settle(2'b01);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (i == 4) check("R7 up low after clear", int'(up_o), 0);
      if (i == 4) check("R3 dn low after clear", int'(dn_o), 0);
      if (i == 7) check("R7 up stays low", int'(up_o), 0);
      case (i)
        0: ref_in = 1'b1;
        1: ref_in = 1'b0;
        2: fb_in  = 1'b1;
        3: ref_in = 1'b1;
        default: ;
      endcase
    end

    // R8: selector changed mid-pulse does not shorten it
    settle(2'b10);
    up_cnt = 0; dn_cnt = 0;
    for (int i = 0; i < 14; i++) begin
      @(negedge clk);
      if (up_o) up_cnt++;
      if (dn_o) dn_cnt++;
      if (i == 0) begin ref_in = 1'b1; fb_in = 1'b1; end
      if (i == 2) delay_sel = 2'b01;
    end
    check("R8 up width held", up_cnt, 5);
    check("R8 dn width held", dn_cnt, 5);

    // R1: reset during a pulse drops both outputs
    settle(2'b10);
    @(negedge clk); ref_in = 1'b1;
    @(negedge clk); @(negedge clk);
    check("R2 up set before reset", int'(up_o), 1);
    rst = 1'b1;
    @(negedge clk);
    check("R1 up cleared by reset", int'(up_o), 0);
    rst = 1'b0;

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule